// File: doc/BRIEF.md
# Core Power-Up Sequencer

This block brings a secondary processor core out of power-down without software stepping through each register write. A single start pulse names the core. The block first looks at the shared reset-control word. If that core's active-low reset is already released, it reports completion and does nothing else.

Otherwise it takes the core's current power-control register value and builds on it step by step. The steps come in a fixed order: logic power on, logic power good, logic clamp release, RAM power-down release, RAM power on, RAM power good, RAM clamp release. Each step emits one register write. The four power steps each wait for their own status field in the register's readback. A final write to the shared control word releases the core's reset.

Every status wait is bounded by a cycle limit supplied on an input. When a wait runs out, the block stops with an error and leaves the reset asserted. Only one sequence runs at a time. A core index outside the supported range is rejected with an error, and no register is written.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset, busy_o, err_o, done_o, skipped_o, pwr_wr_o and ctrl_wr_o are 0, and pwr_word_o, ctrl_word_o and pwr_addr_o are 0.
- R2: On an accepted start whose ctrl_word_i has bit 13+core_idx_i set, done_o and skipped_o pulse for one cycle in the next cycle. No write of either register follows, and err_o is cleared.
- R3: A start with core_idx_i of 2 or 3 sets err_o in the next cycle. busy_o stays 0 and no write is issued.
- R4: In the cycle after an accepted start, pwr_wr_o pulses and pwr_word_o equals the sampled pwr_rd_i with bits 21:20 set. pwr_addr_o is 0x34 + 4*core_idx_i and busy_o is 1.
- R5: Once pwr_rd_i[29:28] reads 2'b11, the next write adds bits 17:16.
- R6: Once pwr_rd_i[25:24] reads 2'b11, three back-to-back writes follow. The first clears bit 15, the second clears bits 11:8, and the third sets bit 1.
- R7: Once pwr_rd_i[5] is 1, the next write sets bit 0. Once pwr_rd_i[4] is 1, the next write clears bit 2.
- R8: One cycle after the bit-2 clearing write, ctrl_wr_o and done_o pulse and busy_o falls. ctrl_word_o is the control word sampled at start with bit 13+index set.
- R9: Every write keeps all bits set or cleared by earlier writes of the same sequence. A full run from 0x00008F04 ends at 0x00330003 after exactly 7 writes.
- R10: If a status wait is still unmet at the edge where its counter equals timeout_i (timeout_i+1 edges into the wait), err_o rises, busy_o falls, and no further write is issued.
- R11: Status that arrives on the last allowed edge of a wait counts as met, so the sequence proceeds without error.
- R12: A start while busy_o is 1 is ignored. Index, address, word and saved control word are unaffected.
- R13: A later accepted start clears err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sequence request, sampled when idle |
| core_idx_i | input | 2 | Core to power up |
| ctrl_word_i | input | 32 | Current shared reset-control word |
| pwr_rd_i | input | 32 | Live readback of the selected core's power-control register |
| timeout_i | input | 16 | Status wait limit in cycles |
| pwr_word_o | output | 32 | Value of the latest power-control write |
| pwr_wr_o | output | 1 | Power-control write strobe |
| pwr_addr_o | output | 8 | Power-control register offset |
| ctrl_word_o | output | 32 | Value of the reset-release write |
| ctrl_wr_o | output | 1 | Reset-release write strobe (control offset 0x30) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| skipped_o | output | 1 | Completion was a skip (reset already released) |
| err_o | output | 1 | Timeout or bad index, held until next accepted start |

## Verification
Two events can land on the same clock edge. One is a status field becoming valid; the other is the wait counter reaching timeout_i. The bench's switch responder mirrors written fields into the readback after a chosen latency. Setting that latency equal to the limit makes the status arrive exactly on the final edge, and the run must complete cleanly. One cycle more must end in the error state with reset still held. The second collision is a start arriving while a sequence is in flight. The per-cycle reference model judges that it changes nothing.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_W_ON, ST_W_OK, ST_MPDA, ST_MON, ST_W_MON, ST_W_MOK, ST_RST
  } cps_state_e;

  localparam int LOGIC_ON_LSB  = 20;
  localparam int LOGIC_OK_LSB  = 16;
  localparam int ON_STAT_LSB   = 28;
  localparam int OK_STAT_LSB   = 24;
  localparam int CLAMP_BIT     = 15;
  localparam int MPDA_LSB      = 8;
  localparam int MPDA_W        = 4;
  localparam int MEM_OK_BIT    = 0;
  localparam int MEM_ON_BIT    = 1;
  localparam int MEM_CLAMP_BIT = 2;
  localparam int MEM_OK_STAT   = 4;
  localparam int MEM_ON_STAT   = 5;
  localparam int RST_N_LSB     = 13;
  localparam int PWR_BASE      = 'h34;
  localparam int PWR_STRIDE    = 4;
endpackage

// File: rtl/cps_status_match.sv
module cps_status_match
  import cps_pkg::*;
#(
  parameter int DW = 32
) (
  input  cps_state_e      state_i,
  input  logic [DW-1:0]   rd_i,
  output logic            met_o
);
  always_comb begin
    unique case (state_i)
      ST_W_ON:  met_o = (rd_i[ON_STAT_LSB +: 2] == 2'b11);
      ST_W_OK:  met_o = (rd_i[OK_STAT_LSB +: 2] == 2'b11);
      ST_W_MON: met_o = rd_i[MEM_ON_STAT];
      ST_W_MOK: met_o = rd_i[MEM_OK_STAT];
      default:  met_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cps_word_next.sv
module cps_word_next
  import cps_pkg::*;
#(
  parameter int DW = 32
) (
  input  cps_state_e      state_i,
  input  logic [DW-1:0]   cur_i,
  input  logic [DW-1:0]   rd_i,
  output logic [DW-1:0]   nxt_o
);
  localparam logic [DW-1:0] ON_M     = DW'(3) << LOGIC_ON_LSB;
  localparam logic [DW-1:0] OK_M     = DW'(3) << LOGIC_OK_LSB;
  localparam logic [DW-1:0] CLAMP_M  = DW'(1) << CLAMP_BIT;
  localparam logic [DW-1:0] MPDA_M   = DW'((1 << MPDA_W) - 1) << MPDA_LSB;
  localparam logic [DW-1:0] MON_M    = DW'(1) << MEM_ON_BIT;
  localparam logic [DW-1:0] MOK_M    = DW'(1) << MEM_OK_BIT;
  localparam logic [DW-1:0] MCLAMP_M = DW'(1) << MEM_CLAMP_BIT;

  always_comb begin
    unique case (state_i)
      ST_IDLE:  nxt_o = rd_i  | ON_M;
      ST_W_ON:  nxt_o = cur_i | OK_M;
      ST_W_OK:  nxt_o = cur_i & ~CLAMP_M;
      ST_MPDA:  nxt_o = cur_i & ~MPDA_M;
      ST_MON:   nxt_o = cur_i | MON_M;
      ST_W_MON: nxt_o = cur_i | MOK_M;
      ST_W_MOK: nxt_o = cur_i & ~MCLAMP_M;
      default:  nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/cps_wait_timer.sv
module cps_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + TW'(1);
  end

  assign expired_o = (cnt_q == limit_i);
endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import cps_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int TW    = 16,
  parameter int IW    = 2,
  parameter int NCORE = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [IW-1:0] core_idx_i,
  input  logic [DW-1:0] ctrl_word_i,
  input  logic [DW-1:0] pwr_rd_i,
  input  logic [TW-1:0] timeout_i,
  output logic [DW-1:0] pwr_word_o,
  output logic          pwr_wr_o,
  output logic [AW-1:0] pwr_addr_o,
  output logic [DW-1:0] ctrl_word_o,
  output logic          ctrl_wr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          skipped_o,
  output logic          err_o
);
  cps_state_e    state_q, succ;
  logic [DW-1:0] word_nxt, ctrl_sav_q;
  logic [IW-1:0] idx_q;
  logic          met, expired, waiting, idx_bad, rst_rel;

  assign waiting = (state_q == ST_W_ON) || (state_q == ST_W_OK) ||
                   (state_q == ST_W_MON) || (state_q == ST_W_MOK);
  assign idx_bad = (core_idx_i >= IW'(NCORE));
  assign rst_rel = ctrl_word_i[RST_N_LSB + int'(core_idx_i)];
  assign busy_o  = (state_q != ST_IDLE);

  cps_status_match #(.DW(DW)) u_match (
    .state_i(state_q), .rd_i(pwr_rd_i), .met_o(met)
  );

  cps_word_next #(.DW(DW)) u_next (
    .state_i(state_q), .cur_i(pwr_word_o), .rd_i(pwr_rd_i), .nxt_o(word_nxt)
  );

  cps_wait_timer #(.TW(TW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(!waiting || met),
    .limit_i(timeout_i), .expired_o(expired)
  );

  always_comb begin
    unique case (state_q)
      ST_W_ON:  succ = ST_W_OK;
      ST_W_OK:  succ = ST_MPDA;
      ST_MPDA:  succ = ST_MON;
      ST_MON:   succ = ST_W_MON;
      ST_W_MON: succ = ST_W_MOK;
      ST_W_MOK: succ = ST_RST;
      default:  succ = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pwr_word_o  <= '0;
      pwr_wr_o    <= 1'b0;
      pwr_addr_o  <= '0;
      ctrl_word_o <= '0;
      ctrl_sav_q  <= '0;
      ctrl_wr_o   <= 1'b0;
      idx_q       <= '0;
      done_o      <= 1'b0;
      skipped_o   <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      pwr_wr_o  <= 1'b0;
      ctrl_wr_o <= 1'b0;
      done_o    <= 1'b0;
      skipped_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (idx_bad) begin
            err_o <= 1'b1;
          end else if (rst_rel) begin
            err_o     <= 1'b0;
            done_o    <= 1'b1;
            skipped_o <= 1'b1;
          end else begin
            err_o      <= 1'b0;
            idx_q      <= core_idx_i;
            ctrl_sav_q <= ctrl_word_i;
            pwr_addr_o <= AW'(PWR_BASE) + AW'(PWR_STRIDE) * AW'(core_idx_i);
            pwr_word_o <= word_nxt;
            pwr_wr_o   <= 1'b1;
            state_q    <= ST_W_ON;
          end
        end
        ST_MPDA, ST_MON: begin
          pwr_word_o <= word_nxt;
          pwr_wr_o   <= 1'b1;
          state_q    <= succ;
        end
        ST_RST: begin
          ctrl_word_o <= ctrl_sav_q | (DW'(1) << (RST_N_LSB + int'(idx_q)));
          ctrl_wr_o   <= 1'b1;
          done_o      <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: begin
          if (met) begin
            pwr_word_o <= word_nxt;
            pwr_wr_o   <= 1'b1;
            state_q    <= succ;
          end else if (expired) begin
            err_o   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R3
  bad_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && idx_bad) |=> (err_o && !pwr_wr_o && !busy_o));

  // R2
  skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !idx_bad && rst_rel) |=>
      (done_o && skipped_o && !pwr_wr_o && !busy_o && !err_o));

  // R4
  start_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !idx_bad && !rst_rel) |=>
      (pwr_wr_o && busy_o && pwr_word_o[LOGIC_ON_LSB +: 2] == 2'b11));

  // R8
  rel_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_o |-> (done_o && !skipped_o && !busy_o && !pwr_wr_o));

  // R10
  timeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waiting && !met && expired) |=> (err_o && !busy_o && !pwr_wr_o && !ctrl_wr_o));
endmodule

// File: tb/core_pwr_seq_tb.sv
module core_pwr_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] INIT = 32'h0000_8F04;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0]  idx = 0;
  logic [31:0] ctrl_in = 0, rd_q = INIT;
  logic [15:0] tmo = 16'd20;
  logic [31:0] pwr_word, ctrl_word;
  logic [7:0]  pwr_addr;
  logic pwr_wr, ctrl_wr, busy, done, skipped, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_pwr_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .core_idx_i(idx),
    .ctrl_word_i(ctrl_in), .pwr_rd_i(rd_q), .timeout_i(tmo),
    .pwr_word_o(pwr_word), .pwr_wr_o(pwr_wr), .pwr_addr_o(pwr_addr),
    .ctrl_word_o(ctrl_word), .ctrl_wr_o(ctrl_wr), .busy_o(busy),
    .done_o(done), .skipped_o(skipped), .err_o(err)
  );

  int n_cmp = 0, n_bad = 0, wr_cnt = 0, lat = 0, dly = 0;
  bit finished = 0, stuck = 0, armed = 0, skip_seen = 0, rel_seen = 0;
  string cur_req = "R1";
  logic [31:0] pend;

  // reference model state
  bit m_busy, e_wr, e_cwr, e_done, e_skip, m_err;
  int m_phase, m_cnt;
  logic [1:0]  m_idx;
  logic [31:0] m_word, m_sav, m_ctrl;
  logic [7:0]  m_addr;

  task automatic m_tmo();
    if (m_cnt == int'(tmo)) begin m_err = 1; m_busy = 0; m_phase = 0; end
    else m_cnt++;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; e_wr = 0; e_cwr = 0; e_done = 0; e_skip = 0; m_err = 0;
      m_phase = 0; m_cnt = 0; m_idx = 0; m_word = 0; m_sav = 0; m_ctrl = 0; m_addr = 0;
    end else begin
      e_wr = 0; e_cwr = 0; e_done = 0; e_skip = 0;
      if (!m_busy) begin
        if (start) begin
          if (idx > 1) m_err = 1;
          else if (ctrl_in[13 + idx]) begin e_done = 1; e_skip = 1; m_err = 0; end
          else begin
            m_err = 0; m_busy = 1; m_idx = idx; m_sav = ctrl_in;
            m_addr = 8'h34 + 8'(4 * idx);
            m_word = rd_q | 32'h0030_0000; e_wr = 1; m_phase = 1; m_cnt = 0;
          end
        end
      end else begin
        case (m_phase)
          1: if (rd_q[29:28] == 2'b11) begin m_word |= 32'h0003_0000; e_wr = 1; m_phase = 2; m_cnt = 0; end
             else m_tmo();
          2: if (rd_q[25:24] == 2'b11) begin m_word &= ~32'h0000_8000; e_wr = 1; m_phase = 3; end
             else m_tmo();
          3: begin m_word &= ~32'h0000_0F00; e_wr = 1; m_phase = 4; end
          4: begin m_word |= 32'h2; e_wr = 1; m_phase = 5; m_cnt = 0; end
          5: if (rd_q[5]) begin m_word |= 32'h1; e_wr = 1; m_phase = 6; m_cnt = 0; end
             else m_tmo();
          6: if (rd_q[4]) begin m_word &= ~32'h4; e_wr = 1; m_phase = 7; end
             else m_tmo();
          default: begin
            m_ctrl = m_sav | (32'd1 << (13 + m_idx)); e_cwr = 1; e_done = 1;
            m_busy = 0; m_phase = 0;
          end
        endcase
      end
    end
  end

  bit cyc_bad;
  task automatic cmp(string f, logic [31:0] a, logic [31:0] e);
    if (a !== e) begin
      cyc_bad = 1;
      $display("FAIL %s %s act=%h exp=%h t=%0t", cur_req, f, a, e, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    n_cmp++; cyc_bad = 0;
    cmp("word", pwr_word, m_word);  cmp("wr", 32'(pwr_wr), 32'(e_wr));
    cmp("addr", 32'(pwr_addr), 32'(m_addr));
    cmp("ctrl", ctrl_word, m_ctrl); cmp("cwr", 32'(ctrl_wr), 32'(e_cwr));
    cmp("busy", 32'(busy), 32'(m_busy)); cmp("done", 32'(done), 32'(e_done));
    cmp("skip", 32'(skipped), 32'(e_skip)); cmp("err", 32'(err), 32'(m_err));
    if (cyc_bad) n_bad++;
    if (pwr_wr) wr_cnt++;
    if (skipped) skip_seen = 1;
    if (ctrl_wr) rel_seen = 1;
  end

  // power switch responder: mirrors written fields into status after lat cycles
  always @(negedge clk) begin
    if (pwr_wr) begin pend = pwr_word; dly = lat; armed = 1; end
    if (armed && !stuck) begin
      if (dly == 0) begin
        rd_q = (pend & 32'h00FF_FFCF) | (32'(pend[21:20]) << 28) |
               (32'(pend[17:16]) << 24) | (32'(pend[1]) << 5) | (32'(pend[0]) << 4);
        armed = 0;
      end else dly--;
    end
  end

  task automatic xchk(string req, logic [31:0] a, logic [31:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, a, e);
    end
  endtask

  task automatic run(logic [1:0] i, logic [31:0] c, int l, int t, bit stk, string req);
    @(negedge clk);
    rd_q = INIT; lat = l; tmo = 16'(t); stuck = stk; cur_req = req;
    wr_cnt = 0; skip_seen = 0; rel_seen = 0;
    start = 1; idx = i; ctrl_in = c;
    @(negedge clk); start = 0;
    repeat (60) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    xchk("R1", {busy, err, done, skipped, pwr_wr, ctrl_wr}, 0);
    xchk("R1", pwr_word | ctrl_word | 32'(pwr_addr), 0);

    run(0, 32'h1, 0, 20, 0, "R4 R5 R6 R7 R8 R9");
    xchk("R9", pwr_word, 32'h0033_0003);
    xchk("R5 R6 R7", 32'(wr_cnt), 7);
    xchk("R8", ctrl_word, 32'h0000_2001);
    xchk("R4", 32'(pwr_addr), 32'h34);

    // R12: second start while busy
    @(negedge clk);
    rd_q = INIT; lat = 3; tmo = 16'd20; stuck = 0; cur_req = "R12";
    wr_cnt = 0; rel_seen = 0;
    start = 1; idx = 1; ctrl_in = 32'h0000_2000;
    @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    start = 1; idx = 0; ctrl_in = 32'h0;
    @(negedge clk); start = 0;
    repeat (60) @(negedge clk);
    xchk("R12", 32'(pwr_addr), 32'h38);
    xchk("R12", ctrl_word, 32'h0000_6000);
    xchk("R12", 32'(wr_cnt), 7);

    run(1, 32'h0000_4000, 0, 20, 0, "R2");
    xchk("R2", 32'(wr_cnt), 0);
    xchk("R2", 32'(skip_seen), 1);
    xchk("R2", 32'(rel_seen), 0);

    run(0, 32'h0000_4000, 0, 20, 0, "R2 R8");
    xchk("R8", ctrl_word, 32'h0000_6000);
    xchk("R2", 32'(skip_seen), 0);

    run(2, 32'h0, 0, 20, 0, "R3");
    xchk("R3", 32'(err), 1);
    xchk("R3", 32'(wr_cnt), 0);
    run(3, 32'h0, 0, 20, 0, "R3");
    xchk("R3", 32'(wr_cnt), 0);

    run(0, 32'h0, 0, 4, 1, "R10");
    xchk("R10", 32'(err), 1);
    xchk("R10", 32'(wr_cnt), 1);
    xchk("R10", 32'(rel_seen), 0);

    run(1, 32'h0, 3, 3, 0, "R11 R13");
    xchk("R13", 32'(err), 0);
    xchk("R11", 32'(rel_seen), 1);
    xchk("R11", 32'(wr_cnt), 7);

    run(1, 32'h0, 4, 3, 0, "R10");
    xchk("R10", 32'(err), 1);
    xchk("R10", 32'(wr_cnt), 1);

    run(0, 32'h0, 0, 0, 0, "R11 R13");
    xchk("R13", 32'(err), 0);
    xchk("R11", 32'(rel_seen), 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule